// File: doc/BRIEF.md
# Nonvolatile Write Protection Gate

This block sits beside a 4096-byte nonvolatile array and rules on every write the serial front end wants to commit. It owns a small protection register that software reaches by writing the top array address (0xFFF). The register combines three layers of protection:

- a software enable latch that must be set before anything is written;
- a block selector that locks a quarter, a half or all of the array, always counted from the top;
- a hardware-enable bit. Together with a write-protect input pin, this bit freezes the protection settings.

For each write request the block returns a registered allow or deny verdict one clock later. The front end uses that verdict to decide whether to launch the internal write cycle. A denied write still finishes its bus transaction normally. The current register contents are always visible for readback.

Top module: `nvwr_guard`

## Requirements
- R1: After synchronous reset the readback word `prot_q` is 0x00: latch clear, no block locked, hardware enable clear. `wr_valid` and `wr_allow` are low.
- R2: While the latch (`prot_q` bit 0) is clear, every write request is denied (`wr_allow`=0), whether it targets the array or the register.
- R3: The block selector (`prot_q` bits 2:1) locks writes to these regions, and a locked address is denied: 00 locks nothing, 01 locks 0xC00–0xFFF, 10 locks 0x800–0xFFF, 11 locks the whole array. An array write outside the locked region with the latch set is allowed.
- R4: With `wp_pin` low, the hardware-enable bit (`prot_q` bit 7) has no effect. A register write with the latch set is allowed and loads all fields.
- R5: With `wp_pin` high and the hardware-enable bit set, a register write is denied and leaves bits 7:1 of the register unchanged.
- R6: Every register write (address 0xFFF) loads data bit 0 into the latch, even when the write is denied or the latch was clear. The latch may be set or cleared this way.
- R7: `wr_valid` pulses high exactly one clock after each cycle with `wr_req` high, and `wr_allow` carries that request's verdict. When no request was made, both are low.
- R8: An allowed register write loads data bits 2:1 into the selector and data bit 7 into the hardware enable. Data bits 6:3 are not stored, and bits 6:3 of `prot_q` read 0. Without a request the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | One-cycle write request strobe |
| wr_addr | input | 12 | Target byte address; 0xFFF selects the protection register |
| wr_data | input | 8 | Write data, used for register updates |
| wp_pin | input | 1 | Write-protect pin level |
| wr_valid | output | 1 | Verdict strobe, one clock after the request |
| wr_allow | output | 1 | Verdict: 1 lets the internal write cycle start |
| prot_q | output | 8 | Protection register readback |

## Verification
The verdict (`wr_valid`, `wr_allow`) and any register change appear at the first rising edge after the request cycle. `prot_q` therefore shows the new settings from that edge on. The bench drives inputs just after a falling edge. Its behavioural model updates at the rising edge, and all three outputs are compared with the model at the next falling edge. Every output is checked one clock after its cause, on every cycle, including idle gaps and back-to-back requests.

// File: rtl/nvwr_guard_pkg.sv
package nvwr_guard_pkg;

    // Field positions that software relies on
    localparam int WEL_BIT  = 0;
    localparam int BSEL_LSB = 1;

    typedef enum logic [1:0] {
        BSEL_NONE = 2'b00,
        BSEL_QTR  = 2'b01,
        BSEL_HALF = 2'b10,
        BSEL_ALL  = 2'b11
    } bsel_e;

    typedef struct packed {
        logic  hw_en;
        bsel_e bsel;
        logic  wel;
    } prot_t;

    function automatic logic region_hit(bsel_e sel, logic [1:0] top2);
        case (sel)
            BSEL_QTR:  return top2 == 2'b11;
            BSEL_HALF: return top2[1];
            BSEL_ALL:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wp_region.sv
module wp_region
    import nvwr_guard_pkg::*;
(
    input  bsel_e      bsel,
    input  logic [1:0] addr_top,
    output logic       locked
);
    always_comb locked = region_hit(bsel, addr_top);
endmodule

// File: rtl/wp_decide.sv
module wp_decide
    import nvwr_guard_pkg::*;
(
    input  logic  req,
    input  logic  is_reg,
    input  prot_t cur,
    input  logic  pin,
    input  logic  in_lock,
    output logic  allow_d,
    output logic  upd_wel,
    output logic  upd_fields
);
    logic hw_frozen;

    always_comb begin
        hw_frozen  = pin & cur.hw_en;
        upd_wel    = 1'b0;
        upd_fields = 1'b0;
        if (is_reg) begin
            allow_d    = cur.wel & ~hw_frozen;
            upd_wel    = req;
            upd_fields = req & allow_d;
        end else begin
            allow_d = cur.wel & ~in_lock;
        end
    end
endmodule

// File: rtl/wp_preg.sv
module wp_preg
    import nvwr_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd_wel,
    input  logic  upd_fields,
    input  logic  wel_d,
    input  bsel_e bsel_d,
    input  logic  hw_d,
    output prot_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (upd_wel)
                q.wel <= wel_d;
            if (upd_fields) begin
                q.bsel  <= bsel_d;
                q.hw_en <= hw_d;
            end
        end
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!upd_wel && !upd_fields) |=> $stable(q)); // R8
endmodule

// File: rtl/nvwr_guard.sv
module nvwr_guard
    import nvwr_guard_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_pin,
    output logic              wr_valid,
    output logic              wr_allow,
    output logic [DATA_W-1:0] prot_q
);
    localparam int                HW_BIT   = DATA_W - 1;
    localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

    prot_t cur;
    logic  is_reg, in_lock, allow_d, upd_wel, upd_fields;

    always_comb is_reg = (wr_addr == REG_ADDR);

    wp_region u_region (
        .bsel     (cur.bsel),
        .addr_top (wr_addr[ADDR_W-1 -: 2]),
        .locked   (in_lock)
    );

    wp_decide u_decide (
        .req        (wr_req),
        .is_reg     (is_reg),
        .cur        (cur),
        .pin        (wp_pin),
        .in_lock    (in_lock),
        .allow_d    (allow_d),
        .upd_wel    (upd_wel),
        .upd_fields (upd_fields)
    );

    wp_preg u_preg (
        .clk        (clk),
        .rst        (rst),
        .upd_wel    (upd_wel),
        .upd_fields (upd_fields),
        .wel_d      (wr_data[WEL_BIT]),
        .bsel_d     (bsel_e'(wr_data[BSEL_LSB +: 2])),
        .hw_d       (wr_data[HW_BIT]),
        .q          (cur)
    );

    always_comb begin
        prot_q                 = '0;
        prot_q[WEL_BIT]        = cur.wel;
        prot_q[BSEL_LSB +: 2]  = cur.bsel;
        prot_q[HW_BIT]         = cur.hw_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_allow <= 1'b0;
        end else begin
            wr_valid <= wr_req;
            wr_allow <= wr_req & allow_d;
        end
    end

    AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> wr_valid); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> (!wr_valid && !wr_allow)); // R7
    AST_WEL_GATES: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !prot_q[WEL_BIT]) |=> !wr_allow); // R2
    AST_ALL_LOCK: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !is_reg && prot_q[BSEL_LSB +: 2] == 2'b11) |=> !wr_allow); // R3
    AST_HW_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (wr_req && is_reg && wp_pin && prot_q[HW_BIT])
        |=> (!wr_allow && prot_q[HW_BIT:1] == $past(prot_q[HW_BIT:1]))); // R5
    AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (wr_req && is_reg) |=> prot_q[WEL_BIT] == $past(wr_data[WEL_BIT])); // R6
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        prot_q[HW_BIT-1:BSEL_LSB+2] == '0); // R8
endmodule

// File: tb/nvwr_guard_test.sv
module nvwr_guard_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_req = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wp_pin = 1'b0;
    logic        wr_valid, wr_allow;
    logic [7:0]  prot_q;

    nvwr_guard uut (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wp_pin(wp_pin), .wr_valid(wr_valid),
        .wr_allow(wr_allow), .prot_q(prot_q)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    run = 0;
    bit    done = 0;

    // behavioural reference
    int m_wel = 0, m_blk = 0, m_hw = 0, e_valid = 0, e_allow = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_wel = 0; m_blk = 0; m_hw = 0; e_valid = 0; e_allow = 0;
        end else begin
            e_valid = wr_req;
            e_allow = 0;
            if (wr_req) begin
                if (wr_addr == 12'hFFF) begin
                    bit ok;
                    ok = (m_wel == 1) && !(wp_pin && m_hw == 1);
                    e_allow = ok;
                    if (ok) begin
                        m_blk = (wr_data >> 1) & 3;
                        m_hw  = wr_data[7];
                    end
                    m_wel = wr_data[0];
                end else begin
                    bit locked;
                    case (m_blk)
                        1: locked = (wr_addr >= 12'hC00);
                        2: locked = (wr_addr >= 12'h800);
                        3: locked = 1;
                        default: locked = 0;
                    endcase
                    e_allow = (m_wel == 1) && !locked;
                end
            end
        end
    end

    task automatic chk(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    always @(negedge clk) if (run) begin
        chk(tag, "wr_valid", int'(wr_valid), e_valid);
        chk(tag, "wr_allow", int'(wr_allow), e_allow);
        chk(tag, "prot_q", int'(prot_q), (m_hw << 7) | (m_blk << 1) | m_wel);
    end

    task automatic issue(logic [11:0] a, logic [7:0] d);
        @(negedge clk); #1;
        wr_req = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            wr_req = 1'b0;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset prot_q", int'(prot_q), 0);
        chk("R1", "reset wr_valid", int'(wr_valid), 0);
        chk("R1", "reset wr_allow", int'(wr_allow), 0);
        run = 1;
        idle(2);

        tag = "R2";
        issue(12'h100, 8'h55);
        issue(12'hFFF, 8'h86);   // latch stays clear, fields refused
        idle(2);

        tag = "R6";
        issue(12'hFFF, 8'h07);   // sets latch only
        issue(12'hFFF, 8'h00);   // allowed, clears latch
        issue(12'hFFF, 8'h01);   // sets latch again
        idle(1);

        tag = "R3";
        issue(12'hFFF, 8'h03);   // quarter
        issue(12'hBFF, 8'h11);
        issue(12'hC00, 8'h11);
        issue(12'hFFE, 8'h11);
        idle(1);
        issue(12'hFFF, 8'h05);   // half
        issue(12'h7FF, 8'h22);
        issue(12'h800, 8'h22);
        issue(12'hFFF, 8'h07);   // all
        issue(12'h000, 8'h33);
        issue(12'h400, 8'h33);
        issue(12'hFFF, 8'h01);   // none
        issue(12'hFFE, 8'h44);
        idle(2);

        tag = "R4";
        wp_pin = 1'b0;
        issue(12'hFFF, 8'h81);
        issue(12'hFFF, 8'h83);
        issue(12'h100, 8'h00);
        idle(1);

        tag = "R5";
        issue(12'hFFF, 8'h81);   // pin still low: allowed
        idle(1);
        issue(12'hFFF, 8'h83);   // set quarter lock, hw on
        idle(1);
        wp_pin = 1'b1;
        issue(12'hFFF, 8'h01);   // frozen
        issue(12'hC00, 8'h00);
        issue(12'h100, 8'h00);
        issue(12'hFFF, 8'h00);   // latch clears, rest frozen
        issue(12'h100, 8'h00);
        idle(1);
        wp_pin = 1'b0;
        issue(12'hFFF, 8'h01);
        issue(12'hFFF, 8'h01);   // unlock all fields
        idle(2);

        tag = "R8";
        issue(12'hFFF, 8'h7F);   // spare bits dropped
        idle(3);
        issue(12'hFFF, 8'hF9);
        idle(2);

        tag = "R7";
        for (int i = 0; i < 20; i++) begin
            issue(12'((i * 211) & 12'hFFF), 8'(i * 37));
            if (i % 3 == 0) idle(i % 4);
        end
        idle(3);

        run = 0;
        finish_up();
    end
endmodule